// File: doc/BRIEF.md
# Bit-Addressable General-Purpose I/O Port

This block is an eight-pin general-purpose I/O port that sits on a small register bus. Software reaches it through three register selects: a direction register, an output-data register and a read-only view of the pins. Bus writes come in three kinds. A whole-register load replaces all bits. A bit set and a bit clear each touch only the one bit named by a bit index. These two give atomic read-modify-write on a single pin, so firmware never has to read, mask and write back.

For every pin the block drives three pad controls: an output enable, an output level and a pull-up enable. A pin with its direction bit at 1 drives its data bit. A pin with its direction bit at 0 is an input, and its data bit then turns that pin's pull-up on. A global pull-up-off input overrides every pull-up. Each pin also takes an alternate-function override. When the override is on, a peripheral's output enable and output level replace the register-driven ones and the pull-up is forced off. Pins without the override keep working as plain I/O. The pins are read back through a two-stage synchronizer.

The design has no sequencing state of its own. The register file is a set of plain flip-flops. The two-stage synchronizer is a fixed pipeline with no choice of transition. The read path is a combinational selector, decoded by a `unique case` over the named register selects `SEL_PIN`, `SEL_DIR`, `SEL_DAT` and `SEL_NONE`.

Top module: `gpio_bitport`

## Requirements
- R1: After reset the direction and data registers read 0, and all pins show pin_oe=0, pin_out=0 and pin_pu=0 while alt_en is 0.
- R2: A write with bus_op=0 (load) to select 1 (direction) or select 2 (data) replaces that whole register at the next clock edge.
- R3: A write with bus_op=1 (set) to select 1 or 2 sets bit bus_bit of that register and leaves every other bit of both registers unchanged.
- R4: A write with bus_op=2 (clear) clears bit bus_bit of the selected register and leaves all other bits unchanged. A write with bus_op=3 changes nothing.
- R5: For a pin whose direction bit is 1 and whose alt_en bit is 0, pin_oe is 1, pin_out equals the data bit and pin_pu is 0.
- R6: For a pin whose direction bit is 0 and whose alt_en bit is 0, pin_oe is 0 and pin_pu equals the data bit while pu_off is 0. pin_out always equals the data bit on pins without the override.
- R7: While pu_off is 1, pin_pu is 0 on every pin, whatever the direction and data bits are.
- R8: For a pin with alt_en=1, pin_oe equals alt_oe, pin_out equals alt_out and pin_pu is 0. Pins with alt_en=0 are unaffected.
- R9: Reading select 0 returns pad_in as it was two clock edges earlier, whatever the direction setting.
- R10: Writes of any kind to select 0 or select 3 change no register. Select 3 reads as 0.
- R11: bus_rdata follows bus_addr combinationally, with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 pins, 1 direction, 2 data, 3 unused |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_op | input | 2 | Write kind: 0 load, 1 set bit, 2 clear bit, 3 none |
| bus_bit | input | 3 | Bit index for set and clear |
| bus_wdata | input | 8 | Load data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pu_off | input | 1 | Global pull-up disable |
| pad_in | input | 8 | Asynchronous pad levels |
| alt_en | input | 8 | Per-pin alternate-function override |
| alt_oe | input | 8 | Alternate output enables |
| alt_out | input | 8 | Alternate output levels |
| pin_oe | output | 8 | Pad output enables |
| pin_out | output | 8 | Pad output levels |
| pin_pu | output | 8 | Pad pull-up enables |

## Verification
The bench provokes two collisions. In the first, a bit-set on the data register lands in the same clock cycle as an alternate-function override rising on a different pin. In the second, a whole-register load lands in the cycle in which the pad pattern changes. In each case the readback is compared with a bench-side model of the register, and the per-pin outputs are compared with the rules for plain and overridden pins. This shows that a bus write does not disturb an override on another pin, and that the synchronizer is independent of direction writes.

// File: rtl/gpio_bitport_pkg.sv
package gpio_bitport_pkg;

    typedef enum logic [1:0] {
        SEL_PIN  = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_DAT  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_NOP  = 2'd3
    } wr_op_e;

endpackage

// File: rtl/gpio_bitport_regs.sv
module gpio_bitport_regs
    import gpio_bitport_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  reg_sel_e         sel,
    input  wr_op_e           op,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] dat_q
);

    logic [WIDTH-1:0] mask;
    logic [WIDTH-1:0] dir_d;
    logic [WIDTH-1:0] dat_d;

    function automatic logic [WIDTH-1:0] apply_op(
        input logic [WIDTH-1:0] cur,
        input wr_op_e           kind,
        input logic [WIDTH-1:0] m,
        input logic [WIDTH-1:0] d
    );
        logic [WIDTH-1:0] r;
        unique case (kind)
            OP_LOAD: r = d;
            OP_SET:  r = cur | m;
            OP_CLR:  r = cur & ~m;
            default: r = cur;
        endcase
        return r;
    endfunction

    always_comb begin
        mask = '0;
        mask[bit_idx] = 1'b1;
    end

    always_comb begin
        dir_d = dir_q;
        dat_d = dat_q;
        if (wr) begin
            unique case (sel)
                SEL_DIR: dir_d = apply_op(dir_q, op, mask, wdata);
                SEL_DAT: dat_d = apply_op(dat_q, op, mask, wdata);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            dat_q <= '0;
        end else begin
            dir_q <= dir_d;
            dat_q <= dat_d;
        end
    end

    AST_SET_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && op == OP_SET && sel == SEL_DIR) |=>
            ((dir_q & ~$past(mask)) == ($past(dir_q) & ~$past(mask))) && $stable(dat_q)); // R3

    AST_SET_HITS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && op == OP_SET && sel == SEL_DAT) |=>
            ((dat_q & $past(mask)) == $past(mask)) && $stable(dir_q)); // R3

    AST_CLR_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && op == OP_CLR && (sel == SEL_DIR || sel == SEL_DAT)) |=>
            (((dir_q ^ $past(dir_q)) | (dat_q ^ $past(dat_q))) & ~$past(mask)) == '0); // R4

    AST_NOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && op == OP_NOP) |=> $stable(dir_q) && $stable(dat_q)); // R4

    AST_PIN_SEL_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (sel == SEL_PIN || sel == SEL_NONE)) |=> $stable(dir_q) && $stable(dat_q)); // R10

endmodule

// File: rtl/gpio_bitport_sync.sv
module gpio_bitport_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bitport_pinmux.sv
module gpio_bitport_pinmux #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] dat_q,
    input  logic             pu_off,
    input  logic [WIDTH-1:0] alt_en,
    input  logic [WIDTH-1:0] alt_oe,
    input  logic [WIDTH-1:0] alt_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_pu
);

    generate
        for (genvar p = 0; p < WIDTH; p++) begin : g_pin
            assign pin_oe[p]  = alt_en[p] ? alt_oe[p]  : dir_q[p];
            assign pin_out[p] = alt_en[p] ? alt_out[p] : dat_q[p];
            assign pin_pu[p]  = !pu_off && !dir_q[p] && dat_q[p] && !alt_en[p];
        end
    endgenerate

    always_comb begin
        AST_ALT_NO_PULL: assert ((alt_en & pin_pu) == '0); // R8
    end

endmodule

// File: rtl/gpio_bitport.sv
module gpio_bitport
    import gpio_bitport_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic [1:0] bus_op,
    input  logic [2:0] bus_bit,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       pu_off,
    input  logic [7:0] pad_in,
    input  logic [7:0] alt_en,
    input  logic [7:0] alt_oe,
    input  logic [7:0] alt_out,
    output logic [7:0] pin_oe,
    output logic [7:0] pin_out,
    output logic [7:0] pin_pu
);

    localparam int unsigned WIDTH       = 8;
    localparam int unsigned SYNC_STAGES = 2;

    reg_sel_e         sel;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] dat_q;
    logic [WIDTH-1:0] pin_sync;
    logic [1:0]       since_rst;

    assign sel = reg_sel_e'(bus_addr);

    gpio_bitport_regs #(.WIDTH(WIDTH)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .sel     (sel),
        .op      (wr_op_e'(bus_op)),
        .bit_idx (bus_bit),
        .wdata   (bus_wdata),
        .dir_q   (dir_q),
        .dat_q   (dat_q)
    );

    gpio_bitport_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio_bitport_pinmux #(.WIDTH(WIDTH)) i_pinmux (
        .dir_q   (dir_q),
        .dat_q   (dat_q),
        .pu_off  (pu_off),
        .alt_en  (alt_en),
        .alt_oe  (alt_oe),
        .alt_out (alt_out),
        .pin_oe  (pin_oe),
        .pin_out (pin_out),
        .pin_pu  (pin_pu)
    );

    always_comb begin
        unique case (sel)
            SEL_PIN:  bus_rdata = pin_sync;
            SEL_DIR:  bus_rdata = dir_q;
            SEL_DAT:  bus_rdata = dat_q;
            SEL_NONE: bus_rdata = '0;
            default:  bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_PIN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && bus_addr == 2'd0) |-> bus_rdata == $past(pad_in, 2)); // R9

    AST_GLOBAL_PULL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        pu_off |-> pin_pu == '0); // R7

    AST_PULL_ONLY_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & pin_oe) == '0); // R6

    AST_OUT_PIN_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr == 2'd1) && (alt_en == '0)) |-> pin_oe == bus_rdata); // R5

endmodule

// File: tb/test_gpio_bitport.sv
module test_gpio_bitport;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_op = 2'd0;
    logic [2:0] bus_bit = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       pu_off = 1'b0;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] alt_en = 8'h00;
    logic [7:0] alt_oe = 8'h00;
    logic [7:0] alt_out = 8'h00;
    logic [7:0] pin_oe;
    logic [7:0] pin_out;
    logic [7:0] pin_pu;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    gpio_bitport i_gpio_bitport (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_op(bus_op), .bus_bit(bus_bit), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pu_off(pu_off), .pad_in(pad_in),
        .alt_en(alt_en), .alt_oe(alt_oe), .alt_out(alt_out),
        .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu)
    );

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic bus_do(input logic [1:0] a, input logic [1:0] op, input int b, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_op = op; bus_bit = 3'(b); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(2'd1, v); check("R1", "dir after reset", v, 8'h00);
        rd(2'd2, v); check("R1", "data after reset", v, 8'h00);
        check("R1", "oe after reset", pin_oe, 8'h00);
        check("R1", "out after reset", pin_out, 8'h00);
        check("R1", "pu after reset", pin_pu, 8'h00);
        rd(2'd3, v); check("R10", "unused select reads 0", v, 8'h00);
    endtask

    task automatic t_load;
        logic [7:0] v;
        bus_do(2'd1, 2'd0, 0, 8'hA5);
        bus_do(2'd2, 2'd0, 0, 8'h3C);
        rd(2'd1, v); check("R2", "dir load", v, 8'hA5);
        rd(2'd2, v); check("R11", "data read after select change", v, 8'h3C);
    endtask

    task automatic t_set_clear;
        logic [7:0] v;
        logic [7:0] base;
        for (int b = 0; b < 8; b++) begin
            for (int r = 1; r <= 2; r++) begin
                base = (b % 2 == 0) ? 8'h00 : 8'h5A;
                bus_do(2'(r), 2'd0, 0, base);
                bus_do(2'(3 - r), 2'd0, 0, 8'hC3);
                bus_do(2'(r), 2'd1, b, 8'h00);
                rd(2'(r), v); check("R3", "set bit", v, base | (8'h01 << b));
                rd(2'(3 - r), v); check("R3", "other register kept on set", v, 8'hC3);
                bus_do(2'(r), 2'd0, 0, 8'hFF);
                bus_do(2'(r), 2'd2, b, 8'hFF);
                rd(2'(r), v); check("R4", "clear bit", v, ~(8'h01 << b));
                rd(2'(3 - r), v); check("R4", "other register kept on clear", v, 8'hC3);
            end
        end
        bus_do(2'd1, 2'd0, 0, 8'h69);
        bus_do(2'd1, 2'd3, 2, 8'h00);
        rd(2'd1, v); check("R4", "no-op write", v, 8'h69);
    endtask

    task automatic t_output_input;
        bus_do(2'd1, 2'd0, 0, 8'hFF);
        bus_do(2'd2, 2'd0, 0, 8'h96);
        #1;
        check("R5", "oe all output", pin_oe, 8'hFF);
        check("R5", "out all output", pin_out, 8'h96);
        check("R5", "pu all output", pin_pu, 8'h00);
        bus_do(2'd1, 2'd0, 0, 8'h0F);
        bus_do(2'd2, 2'd0, 0, 8'hF3);
        #1;
        check("R6", "oe mixed", pin_oe, 8'h0F);
        check("R6", "out mixed", pin_out, 8'hF3);
        check("R6", "pu mixed", pin_pu, 8'hF0);
    endtask

    task automatic t_global_off;
        @(negedge clk); pu_off = 1'b1; #1;
        check("R7", "pu with global off", pin_pu, 8'h00);
        check("R7", "oe unaffected by global off", pin_oe, 8'h0F);
        @(negedge clk); pu_off = 1'b0; #1;
        check("R7", "pu restored", pin_pu, 8'hF0);
    endtask

    task automatic t_alt_collision;
        logic [7:0] v;
        @(negedge clk);
        alt_oe = 8'h01; alt_out = 8'h80; alt_en = 8'h81;
        bus_addr = 2'd2; bus_op = 2'd1; bus_bit = 3'd2; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(2'd2, v); check("R3", "set during override change", v, 8'hF7);
        check("R8", "oe with override", pin_oe, 8'h0F);
        check("R8", "out with override", pin_out, 8'hF6);
        check("R8", "pu with override", pin_pu, 8'h70);
        @(negedge clk); alt_en = 8'h00; #1;
        check("R8", "out after override off", pin_out, 8'hF7);
    endtask

    task automatic t_sync;
        logic [7:0] v;
        @(negedge clk); pad_in = 8'h3C;
        bus_addr = 2'd1; bus_op = 2'd0; bus_wdata = 8'hFF; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        rd(2'd0, v); check("R9", "pin after one edge", v, 8'h00);
        @(negedge clk);
        rd(2'd0, v); check("R9", "pin after two edges, all outputs", v, 8'h3C);
        rd(2'd1, v); check("R2", "load during pad change", v, 8'hFF);
    endtask

    task automatic t_ignore;
        logic [7:0] v;
        bus_do(2'd1, 2'd0, 0, 8'h12);
        bus_do(2'd2, 2'd0, 0, 8'h34);
        bus_do(2'd0, 2'd0, 0, 8'hFF);
        bus_do(2'd0, 2'd1, 5, 8'h00);
        bus_do(2'd3, 2'd0, 0, 8'hEE);
        rd(2'd1, v); check("R10", "dir after pin-select writes", v, 8'h12);
        rd(2'd2, v); check("R10", "data after pin-select writes", v, 8'h34);
        rd(2'd0, v); check("R10", "pin read after writes", v, 8'h3C);
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_set_clear();
        t_output_input();
        t_global_off();
        t_alt_collision();
        t_sync();
        t_ignore();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

endmodule